// File: doc/BRIEF.md
# SDRAM Row Boundary Address Decoder

This block turns a physical address into a chip select for one of four memory rows. Software programs each row with one 8-bit upper-limit value. The rows are stacked: each row begins where the previous non-empty row ends, and row 0 begins at address zero. The limits count in 16 MB units, so only the address bits above bit 23 take part in the decode.

An address selects the lowest populated row whose limit is above the address's 16 MB index. The result appears one clock later as a one-hot chip select, a binary row index and a miss flag. The miss flag marks addresses at or above the top of the highest populated row. The block also drives, for every row, its base and its size in 16 MB units, so software can read back how the programmed limits were interpreted.

If a row's limit is not above the running top of the rows below it, that row is empty and is never selected. This covers both an equal limit and, when software breaks the non-decreasing rule, a lower one.

Top module: `row_limit_decoder`

## Requirements
- R1: After reset all four limits read 0, every address gives miss=1 with no chip select, and row_idx reads 0.
- R2: Writing with cfg_we=1 stores cfg_wdata into the limit selected by cfg_sel (0 to 3) on the clock edge. cfg_rdata always shows the limit selected by cfg_sel, with no cycle of delay.
- R3: For each row, row_base is the running top of the rows below it, which is the largest limit among lower-numbered rows (0 for row 0). row_size is the row's limit minus row_base when the row is populated, and 0 otherwise. Row n uses bits [8n+7:8n] of both outputs.
- R4: The 16 MB index is addr_in[31:24]. The selected row is the lowest populated row whose base is at or below the index and whose limit is above it. cs_onehot has bit n set for row n, and row_idx holds n in binary.
- R5: An index at or above the running top of all four rows gives miss=1, cs_onehot=0 and row_idx=0.
- R6: A row whose limit is less than or equal to the running top of the rows below it is empty. Such a row is never selected and reports row_size 0. The rows above it still stack from the running top.
- R7: cs_onehot, row_idx and miss are registered. They reflect the addr_in value and limits present before the preceding rising clock edge.
- R8: addr_in[23:0] has no effect on the decode result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Limit write strobe |
| cfg_sel | input | 2 | Limit register select |
| cfg_wdata | input | 8 | Limit write data, 16 MB units |
| cfg_rdata | output | 8 | Selected limit readback |
| addr_in | input | 32 | Physical address to decode |
| cs_onehot | output | 4 | Registered one-hot chip select |
| row_idx | output | 2 | Registered selected row number |
| miss | output | 1 | Registered out-of-range flag |
| row_base | output | 32 | Per-row base, 8 bits per row, 16 MB units |
| row_size | output | 32 | Per-row size, 8 bits per row, 16 MB units |

## Verification
Several properties are checked on every cycle by the assertions. The chip select is never more than one-hot, and exactly one of "some chip select" or "miss" holds. The row index always points at the asserted select. A row that was empty in the decode cycle never appears selected, and the first cycle after reset always misses. The bench scenarios are what show that the right row is chosen. They cover exact boundary addresses on both sides of each limit, the stacking of bases across an empty row, the handling of a limit that goes down, readback, the low-bit independence, and the one-cycle latency.

// File: rtl/rld_pkg.sv
// Shared constants for the row limit decoder.
// Assumes: limits count in units of 2**GRAN_SHIFT bytes.
package rld_pkg;
    localparam int RLD_ROWS_DEF   = 4;
    localparam int RLD_LIMIT_DEF  = 8;
    localparam int RLD_ADDR_DEF   = 32;
    localparam int RLD_SHIFT_DEF  = 24;
endpackage

// File: rtl/rld_limit_regs.sv
// Limit register file: one LIMIT_W-bit upper limit per row.
// Assumes: synchronous active-low reset clears every limit to 0 (all rows empty).
module rld_limit_regs #(
    parameter int ROWS    = rld_pkg::RLD_ROWS_DEF,
    parameter int LIMIT_W = rld_pkg::RLD_LIMIT_DEF,
    localparam int SEL_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [SEL_W-1:0]           sel,
    input  logic [LIMIT_W-1:0]         wdata,
    output logic [LIMIT_W-1:0]         rdata,
    output logic [ROWS-1:0][LIMIT_W-1:0] limits
);
    // One register per row, each with its own write decode.
    for (genvar g = 0; g < ROWS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                limits[g] <= '0;
            else if (we && (sel == SEL_W'(g)))
                limits[g] <= wdata;
        end
    end

    // Combinational readback of the selected limit.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < ROWS; i++)
            if (sel == SEL_W'(i)) rdata = limits[i];
    end
endmodule

// File: rtl/rld_row_chain.sv
// Row chain: derives each row's base, size and populated flag from the
// cumulative limits. The base of a row is the running top of lower rows.
// Assumes: a limit not above the running top marks its row empty.
module rld_row_chain #(
    parameter int ROWS    = rld_pkg::RLD_ROWS_DEF,
    parameter int LIMIT_W = rld_pkg::RLD_LIMIT_DEF
) (
    input  logic [ROWS-1:0][LIMIT_W-1:0] limits,
    output logic [ROWS-1:0][LIMIT_W-1:0] base,
    output logic [ROWS-1:0][LIMIT_W-1:0] size,
    output logic [ROWS-1:0]              populated,
    output logic [LIMIT_W-1:0]           top
);
    logic [ROWS:0][LIMIT_W-1:0] run_top;

    assign run_top[0] = '0;

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        // Populated when this limit rises above everything below it.
        assign populated[g]  = limits[g] > run_top[g];
        assign base[g]       = run_top[g];
        assign size[g]       = populated[g] ? (limits[g] - run_top[g]) : '0;
        assign run_top[g+1]  = populated[g] ? limits[g] : run_top[g];
    end

    assign top = run_top[ROWS];
endmodule

// File: rtl/rld_match.sv
// Match stage: compares the address index with each row window, picks the
// lowest populated match and registers chip select, index and miss.
// Assumes: populated/base/limits come from the row chain in the same cycle.
module rld_match #(
    parameter int ROWS    = rld_pkg::RLD_ROWS_DEF,
    parameter int LIMIT_W = rld_pkg::RLD_LIMIT_DEF,
    localparam int IDX_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LIMIT_W-1:0]           idx,
    input  logic [ROWS-1:0][LIMIT_W-1:0] limits,
    input  logic [ROWS-1:0][LIMIT_W-1:0] base,
    input  logic [ROWS-1:0]              populated,
    output logic [ROWS-1:0]              cs_q,
    output logic [IDX_W-1:0]             row_q,
    output logic                         miss_q
);
    logic [ROWS-1:0]  in_win;
    logic [ROWS-1:0]  cs_d;
    logic [IDX_W-1:0] row_d;
    logic             miss_d;

    // Per-row window test: base <= idx < limit on a populated row.
    for (genvar g = 0; g < ROWS; g++) begin : g_win
        assign in_win[g] = populated[g] && (idx >= base[g]) && (idx < limits[g]);
    end

    // Priority pick of the lowest matching row.
    always_comb begin
        cs_d   = '0;
        row_d  = '0;
        miss_d = 1'b1;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (in_win[i]) begin
                cs_d   = '0;
                cs_d[i] = 1'b1;
                row_d  = IDX_W'(i);
                miss_d = 1'b0;
            end
        end
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= '0;
            row_q  <= '0;
            miss_q <= 1'b1;
        end else begin
            cs_q   <= cs_d;
            row_q  <= row_d;
            miss_q <= miss_d;
        end
    end

    // R4: at most one chip select at a time
    a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_q));
    // R5: miss and chip select are mutually exclusive and one of them holds
    a_r5_cs_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q != '0) != miss_q);
    // R4: the row index names the asserted select
    a_r4_idx_match: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_q |-> cs_q[row_q]);
    // R5: a miss reports row index 0
    a_r5_miss_idx: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q |-> (row_q == '0));
    // R6: a row empty in the decode cycle is never selected next cycle
    for (genvar g = 0; g < ROWS; g++) begin : g_chk
        a_r6_empty_unselected: assert property (@(posedge clk) disable iff (!rst_n)
            !populated[g] |=> !cs_q[g]);
    end
    // R1: first cycle out of reset always misses
    a_r1_reset_miss: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (miss_q && cs_q == '0));
endmodule

// File: rtl/row_limit_decoder.sv
// Row limit decoder top: limit registers, row chain and match stage.
// Assumes: rows are programmed as cumulative upper limits in 16 MB units
// (GRAN_SHIFT=24); decode outputs are registered one cycle after the address.
module row_limit_decoder #(
    parameter int ROWS       = rld_pkg::RLD_ROWS_DEF,
    parameter int LIMIT_W    = rld_pkg::RLD_LIMIT_DEF,
    parameter int ADDR_W     = rld_pkg::RLD_ADDR_DEF,
    parameter int GRAN_SHIFT = rld_pkg::RLD_SHIFT_DEF,
    localparam int SEL_W     = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [SEL_W-1:0]          cfg_sel,
    input  logic [LIMIT_W-1:0]        cfg_wdata,
    output logic [LIMIT_W-1:0]        cfg_rdata,
    input  logic [ADDR_W-1:0]         addr_in,
    output logic [ROWS-1:0]           cs_onehot,
    output logic [SEL_W-1:0]          row_idx,
    output logic                      miss,
    output logic [ROWS*LIMIT_W-1:0]   row_base,
    output logic [ROWS*LIMIT_W-1:0]   row_size
);
    logic [ROWS-1:0][LIMIT_W-1:0] limits;
    logic [ROWS-1:0][LIMIT_W-1:0] base;
    logic [ROWS-1:0][LIMIT_W-1:0] size;
    logic [ROWS-1:0]              populated;
    logic [LIMIT_W-1:0]           top;
    logic [LIMIT_W-1:0]           idx;

    // Index in granule units taken from the upper address bits.
    assign idx = addr_in[GRAN_SHIFT +: LIMIT_W];

    rld_limit_regs #(.ROWS(ROWS), .LIMIT_W(LIMIT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .limits(limits)
    );

    rld_row_chain #(.ROWS(ROWS), .LIMIT_W(LIMIT_W)) u_chain (
        .limits(limits), .base(base), .size(size),
        .populated(populated), .top(top)
    );

    rld_match #(.ROWS(ROWS), .LIMIT_W(LIMIT_W)) u_match (
        .clk(clk), .rst_n(rst_n), .idx(idx), .limits(limits),
        .base(base), .populated(populated),
        .cs_q(cs_onehot), .row_q(row_idx), .miss_q(miss)
    );

    assign row_base = base;
    assign row_size = size;

    // R5: an index at or above the running top must miss next cycle
    a_r5_above_top: assert property (@(posedge clk) disable iff (!rst_n)
        (idx >= top) |=> miss);
    // R4: an index below the running top must select a row next cycle
    a_r4_below_top: assert property (@(posedge clk) disable iff (!rst_n)
        (idx < top) |=> !miss);
endmodule

// File: tb/row_limit_decoder_test.sv
module row_limit_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [31:0] addr_in = '0;
    logic [3:0]  cs_onehot;
    logic [1:0]  row_idx;
    logic        miss;
    logic [31:0] row_base;
    logic [31:0] row_size;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    row_limit_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .addr_in(addr_in),
        .cs_onehot(cs_onehot), .row_idx(row_idx), .miss(miss),
        .row_base(row_base), .row_size(row_size)
    );

    // Vector: {addr[31:0], cs[3:0], idx[1:0], miss} for limits {4,4,12,40}
    localparam logic [38:0] VEC [10] = '{
        {32'h0000_0000, 4'b0001, 2'd0, 1'b0},
        {32'h03FF_FFFF, 4'b0001, 2'd0, 1'b0},
        {32'h0300_0000, 4'b0001, 2'd0, 1'b0},
        {32'h0400_0000, 4'b0100, 2'd2, 1'b0},
        {32'h04FF_FF00, 4'b0100, 2'd2, 1'b0},
        {32'h0BFF_FFFF, 4'b0100, 2'd2, 1'b0},
        {32'h0C00_0000, 4'b1000, 2'd3, 1'b0},
        {32'h27FF_FFFF, 4'b1000, 2'd3, 1'b0},
        {32'h2800_0000, 4'b0000, 2'd0, 1'b1},
        {32'hFFFF_FFFF, 4'b0000, 2'd0, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic decode(input logic [31:0] a, input string req,
                          input logic [3:0] ecs, input logic [1:0] eidx, input logic emiss);
        @(negedge clk);
        addr_in = a;
        @(posedge clk);
        #1;
        check(req, {28'd0, cs_onehot}, {28'd0, ecs});
        check(req, {30'd0, row_idx}, {30'd0, eidx});
        check(req, {31'd0, miss}, {31'd0, emiss});
    endtask

    task automatic rd(input logic [1:0] s, input logic [7:0] exp);
        @(negedge clk);
        cfg_sel = s;
        #1;
        check("R2 readback", {24'd0, cfg_rdata}, {24'd0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int i = 0; i < 4; i++) rd(2'(i), 8'd0);
        decode(32'h0000_0000, "R1 reset miss", 4'b0000, 2'd0, 1'b1);
        decode(32'h7F00_0000, "R1 reset miss", 4'b0000, 2'd0, 1'b1);
        check("R1 sizes zero", row_size, 32'd0);

        // R2: program {4,4,12,40}; row 1 empty (R6)
        wr(2'd0, 8'd4); wr(2'd1, 8'd4); wr(2'd2, 8'd12); wr(2'd3, 8'd40);
        rd(2'd0, 8'd4); rd(2'd1, 8'd4); rd(2'd2, 8'd12); rd(2'd3, 8'd40);

        // R3/R6: bases {0,4,4,12}, sizes {4,0,8,28}
        check("R3 bases", row_base, {8'd12, 8'd4, 8'd4, 8'd0});
        check("R3 R6 sizes", row_size, {8'd28, 8'd8, 8'd0, 8'd4});

        // R4/R5/R6/R8: vector table walk
        for (int v = 0; v < 10; v++)
            decode(VEC[v][38:7], "R4 R5 R8 vector", VEC[v][6:3], VEC[v][2:1], VEC[v][0]);

        // R7: output holds the old result until the next edge
        @(negedge clk);
        addr_in = 32'h0C00_0000;
        @(posedge clk); #1;
        @(negedge clk);
        addr_in = 32'h0000_0000;
        #1;
        check("R7 latency hold", {28'd0, cs_onehot}, 32'h8);
        @(posedge clk); #1;
        check("R7 latency update", {28'd0, cs_onehot}, 32'h1);

        // R6: decreasing limits {10,6,20,20}: rows 1 and 3 empty
        wr(2'd0, 8'd10); wr(2'd1, 8'd6); wr(2'd2, 8'd20); wr(2'd3, 8'd20);
        check("R6 R3 bases", row_base, {8'd20, 8'd10, 8'd10, 8'd0});
        check("R6 sizes", row_size, {8'd0, 8'd10, 8'd0, 8'd10});
        decode(32'h0700_0000, "R6 below dropped limit", 4'b0001, 2'd0, 1'b0);
        decode(32'h09FF_FFFF, "R6 row0 top", 4'b0001, 2'd0, 1'b0);
        decode(32'h0A00_0000, "R6 stack past empty", 4'b0100, 2'd2, 1'b0);
        decode(32'h1400_0000, "R5 top boundary", 4'b0000, 2'd0, 1'b1);

        // R1: reset clears limits again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(2'd2, 8'd0);
        decode(32'h0000_0000, "R1 re-reset miss", 4'b0000, 2'd0, 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule